// File: doc/BRIEF.md
# Half-to-single precision bit converter

This unit widens an IEEE 754 binary16 operand to binary32 by taking its sign, exponent and fraction apart and putting them back together at the wider format's positions. It does no arithmetic and raises no exceptions. Every special value comes out exactly as it went in. This includes a signalling NaN, which keeps its quiet bit clear, so a later fused multiply-add stage can still tell which operand was signalling. No rounding is needed, because every binary16 value is exactly representable in binary32.

A binary16 subnormal is normally turned into a normal binary32 value. A flush control can instead turn it into a zero that keeps the input's sign. The datapath is combinational. A parameter places an optional output register after it, which gives a one-cycle latency. The field widths are parameters, and their defaults give the 16-bit to 32-bit case.

Top module: `h2s_convert`

## Requirements
- R1: A normal input (exponent 1 to 30 in bits 14:10) keeps its sign in bit 31. Its exponent gains 112 and lands in bits 30:23. Its 10-bit fraction (bits 9:0) is placed in output bits 22:13, and bits 12:0 are zero. For example, 0x0400 gives 0x38800000.
- R2: An input exponent of 0x1F gives an output exponent of 0xFF, with the sign kept and the fraction carried into bits 22:13 unchanged. For example, 0x7C00 gives 0x7F800000, 0xFC00 gives 0xFF800000 and 0x7E00 gives 0x7FC00000.
- R3: A signalling NaN input (exponent 0x1F, fraction bit 9 clear, fraction nonzero) gives a signalling NaN with output bit 22 clear and its payload kept. For example, 0x7C01 gives 0x7F802000, and 0xFD55 gives 0xFFAAA000.
- R4: An input with a zero exponent and a zero fraction gives a zero exponent and a zero fraction with the same sign: 0x0000 gives 0x00000000 and 0x8000 gives 0x80000000.
- R5: When flush is low, a subnormal input (zero exponent, nonzero fraction) is normalized. The shift is the number of leading zeros of the 10-bit fraction plus 1, which lies between 1 and 10. The output fraction is the input fraction shifted left by the shift, kept to 10 bits. The output exponent is 113 minus the shift. For example, 0x0001 gives exponent 103 (0x33800000), and 0x03FF gives 0x387FC000.
- R6: When flush is high, a subnormal input gives a signed zero (0x83FF gives 0x80000000). Flush has no effect on zero, normal, infinite or NaN inputs.
- R7: With the output register enabled (OUT_REG=1, the default), the result appears one clock after the input is presented, and an active-low reset clears the output to 0. With OUT_REG=0, the output follows the input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset, clears the output register |
| in_half | input | 16 | binary16 operand (sign 15, exponent 14:10, fraction 9:0) |
| flush_sub | input | 1 | When high, subnormal inputs become signed zero |
| out_single | output | 32 | binary32 result (sign 31, exponent 30:23, fraction 22:0) |

## Verification
The bench builds the converter twice with the default field widths. One copy uses OUT_REG=1, so the one-cycle latency and the reset value can be checked. The other uses OUT_REG=0, so the purely combinational path is checked in the same cycle. Both copies are driven with all 65,536 binary16 codes, once with flush low and once with flush high. The comparison is against a model that normalizes subnormals by shifting one place at a time. This reaches every leading-zero count from 0 to 9 and every NaN payload, and directed cases pin down the signed zeros, the infinities, both NaN kinds and the boundary between subnormal and normal.

// File: rtl/h2s_pkg.sv
`timescale 1ns/1ps
package h2s_pkg;

   typedef enum logic [1:0] {
      CLS_ZERO    = 2'd0,
      CLS_SUB     = 2'd1,
      CLS_NORM    = 2'd2,
      CLS_SPECIAL = 2'd3
   } h2s_class_e;

   function automatic int exp_bias(input int exp_w);
      return (1 << (exp_w - 1)) - 1;
   endfunction

endpackage

// File: rtl/h2s_lzc.sv
`timescale 1ns/1ps
// Priority encoder: number of zeros above the highest set bit.
module h2s_lzc #(
   parameter int W  = 10,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] count
);
   always_comb begin
      count = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec[i]) count = CW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/h2s_classify.sv
`timescale 1ns/1ps
module h2s_classify
   import h2s_pkg::*;
#(
   parameter int EXP_W  = 5,
   parameter int FRAC_W = 10
) (
   input  logic [EXP_W-1:0]  exp_f,
   input  logic [FRAC_W-1:0] frac_f,
   output h2s_class_e        cls
);
   logic exp_ones, exp_zero, frac_zero;

   always_comb begin
      exp_ones  = &exp_f;
      exp_zero  = ~|exp_f;
      frac_zero = ~|frac_f;
      if (exp_ones)                    cls = CLS_SPECIAL;
      else if (exp_zero && frac_zero)  cls = CLS_ZERO;
      else if (exp_zero)               cls = CLS_SUB;
      else                             cls = CLS_NORM;
   end
endmodule

// File: rtl/h2s_repack.sv
`timescale 1ns/1ps
module h2s_repack
   import h2s_pkg::*;
#(
   parameter int IN_EXP_W   = 5,
   parameter int IN_FRAC_W  = 10,
   parameter int OUT_EXP_W  = 8,
   parameter int OUT_FRAC_W = 23,
   parameter int CW         = $clog2(IN_FRAC_W + 1)
) (
   input  logic                          sign_f,
   input  logic [IN_EXP_W-1:0]           exp_f,
   input  logic [IN_FRAC_W-1:0]          frac_f,
   input  h2s_class_e                    cls,
   input  logic [CW-1:0]                 lead_zeros,
   input  logic                          flush,
   output logic [OUT_EXP_W+OUT_FRAC_W:0] result
);
   localparam int PAD_W  = OUT_FRAC_W - IN_FRAC_W;
   localparam int REBIAS = exp_bias(OUT_EXP_W) - exp_bias(IN_EXP_W);
   localparam logic [OUT_EXP_W-1:0] REBIAS_V   = OUT_EXP_W'(REBIAS);
   localparam logic [OUT_EXP_W-1:0] SUB_BASE_V = OUT_EXP_W'(REBIAS + 1);

   logic [CW-1:0]         shift;
   logic [IN_FRAC_W-1:0]  frac_norm;
   logic [OUT_EXP_W-1:0]  exp_out;
   logic [IN_FRAC_W-1:0]  frac_out;

   always_comb begin
      shift     = lead_zeros + CW'(1);
      frac_norm = frac_f << shift;
      exp_out   = '0;
      frac_out  = '0;
      unique case (cls)
         CLS_SPECIAL: begin
            exp_out  = '1;
            frac_out = frac_f;
         end
         CLS_ZERO: begin
            exp_out  = '0;
            frac_out = '0;
         end
         CLS_SUB: begin
            if (!flush) begin
               exp_out  = SUB_BASE_V - {{(OUT_EXP_W-CW){1'b0}}, shift};
               frac_out = frac_norm;
            end
         end
         CLS_NORM: begin
            exp_out  = {{(OUT_EXP_W-IN_EXP_W){1'b0}}, exp_f} + REBIAS_V;
            frac_out = frac_f;
         end
         default: ;
      endcase
      result = {sign_f, exp_out, frac_out, {PAD_W{1'b0}}};
   end
endmodule

// File: rtl/h2s_convert.sv
`timescale 1ns/1ps
module h2s_convert
   import h2s_pkg::*;
#(
   parameter int IN_EXP_W   = 5,
   parameter int IN_FRAC_W  = 10,
   parameter int OUT_EXP_W  = 8,
   parameter int OUT_FRAC_W = 23,
   parameter bit OUT_REG    = 1'b1,
   localparam int HW = 1 + IN_EXP_W + IN_FRAC_W,
   localparam int SW = 1 + OUT_EXP_W + OUT_FRAC_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [HW-1:0] in_half,
   input  logic          flush_sub,
   output logic [SW-1:0] out_single
);
   localparam int CW = $clog2(IN_FRAC_W + 1);

   initial begin
      assert (OUT_EXP_W > IN_EXP_W)
         else $error("output exponent must be wider than input exponent");
      assert (OUT_FRAC_W > IN_FRAC_W)
         else $error("output fraction must be wider than input fraction");
      assert (exp_bias(OUT_EXP_W) - exp_bias(IN_EXP_W) > IN_FRAC_W)
         else $error("output exponent range cannot hold input subnormals");
      assert (OUT_EXP_W > CW)
         else $error("shift count does not fit output exponent");
   end

   logic                 sign_f;
   logic [IN_EXP_W-1:0]  exp_f;
   logic [IN_FRAC_W-1:0] frac_f;
   h2s_class_e           cls;
   logic [CW-1:0]        lead_zeros;
   logic [SW-1:0]        packed_word;

   assign sign_f = in_half[HW-1];
   assign exp_f  = in_half[HW-2 -: IN_EXP_W];
   assign frac_f = in_half[IN_FRAC_W-1:0];

   h2s_classify #(.EXP_W(IN_EXP_W), .FRAC_W(IN_FRAC_W)) u_class (
      .exp_f  (exp_f),
      .frac_f (frac_f),
      .cls    (cls)
   );

   h2s_lzc #(.W(IN_FRAC_W), .CW(CW)) u_lzc (
      .vec   (frac_f),
      .count (lead_zeros)
   );

   h2s_repack #(
      .IN_EXP_W   (IN_EXP_W),
      .IN_FRAC_W  (IN_FRAC_W),
      .OUT_EXP_W  (OUT_EXP_W),
      .OUT_FRAC_W (OUT_FRAC_W),
      .CW         (CW)
   ) u_repack (
      .sign_f     (sign_f),
      .exp_f      (exp_f),
      .frac_f     (frac_f),
      .cls        (cls),
      .lead_zeros (lead_zeros),
      .flush      (flush_sub),
      .result     (packed_word)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_single <= '0;
            else        out_single <= packed_word;
         end
      end else begin : g_comb
         assign out_single = packed_word;
      end
   endgenerate
endmodule

// File: rtl/h2s_convert_chk.sv
`timescale 1ns/1ps
module h2s_convert_chk #(
   parameter int IN_EXP_W   = 5,
   parameter int IN_FRAC_W  = 10,
   parameter int OUT_EXP_W  = 8,
   parameter int OUT_FRAC_W = 23,
   parameter bit OUT_REG    = 1'b1,
   localparam int HW = 1 + IN_EXP_W + IN_FRAC_W,
   localparam int SW = 1 + OUT_EXP_W + OUT_FRAC_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic [HW-1:0] in_half,
   input logic          flush_sub,
   input logic [SW-1:0] out_single
);
   localparam int PAD_W   = OUT_FRAC_W - IN_FRAC_W;
   localparam int REBIAS  = ((1 << (OUT_EXP_W-1)) - 1) - ((1 << (IN_EXP_W-1)) - 1);
   localparam int SUB_MIN = REBIAS + 1 - IN_FRAC_W;

   logic [IN_EXP_W-1:0]  ie;
   logic [IN_FRAC_W-1:0] im;
   logic [OUT_EXP_W-1:0] oe;
   logic [IN_FRAC_W-1:0] om;

   assign ie = in_half[HW-2 -: IN_EXP_W];
   assign im = in_half[IN_FRAC_W-1:0];
   assign oe = out_single[SW-2 -: OUT_EXP_W];
   assign om = out_single[OUT_FRAC_W-1 -: IN_FRAC_W];

   generate
      if (OUT_REG) begin : g_chk
         // R1: normal exponent rebiased, fraction moved up, sign kept
         p_norm_rebias_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (ie != '0 && ie != '1) |=>
               (int'(oe) == int'($past(ie)) + REBIAS && om == $past(im)
                && out_single[SW-1] == $past(in_half[HW-1])));

         // R1: low fraction bits of the output are zero
         p_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> out_single[PAD_W-1:0] == '0);

         // R2: all-ones exponent maps to all-ones with fraction carried
         p_special_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ie == '1) |=> (oe == '1 && om == $past(im)
                            && out_single[SW-1] == $past(in_half[HW-1])));

         // R3: a signalling NaN stays signalling
         p_snan_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ie == '1 && !im[IN_FRAC_W-1] && im != '0) |=>
               (!out_single[OUT_FRAC_W-1] && om != '0));

         // R4: signed zero
         p_zero_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ie == '0 && im == '0) |=>
               (out_single[SW-2:0] == '0 && out_single[SW-1] == $past(in_half[HW-1])));

         // R5: a normalized subnormal lands in the subnormal-derived exponent range
         p_sub_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ie == '0 && im != '0 && !flush_sub) |=>
               (int'(oe) >= SUB_MIN && int'(oe) <= REBIAS
                && out_single[SW-1] == $past(in_half[HW-1])));

         // R6: flushed subnormal becomes signed zero
         p_flush_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ie == '0 && im != '0 && flush_sub) |=>
               (out_single[SW-2:0] == '0 && out_single[SW-1] == $past(in_half[HW-1])));
      end
   endgenerate
endmodule

bind h2s_convert h2s_convert_chk #(
   .IN_EXP_W   (IN_EXP_W),
   .IN_FRAC_W  (IN_FRAC_W),
   .OUT_EXP_W  (OUT_EXP_W),
   .OUT_FRAC_W (OUT_FRAC_W),
   .OUT_REG    (OUT_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_half    (in_half),
   .flush_sub  (flush_sub),
   .out_single (out_single)
);

// File: tb/h2s_convert_test.sv
`timescale 1ns/1ps
module h2s_convert_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] in_half = '0;
   logic        flush_sub = 1'b0;
   logic [31:0] out_reg_q;
   logic [31:0] out_comb;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   h2s_convert uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_half    (in_half),
      .flush_sub  (flush_sub),
      .out_single (out_reg_q)
   );

   h2s_convert #(.OUT_REG(1'b0)) uut_comb (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_half    (in_half),
      .flush_sub  (flush_sub),
      .out_single (out_comb)
   );

   function automatic logic [31:0] ref_conv(input logic [15:0] h, input logic f);
      logic        s;
      logic [4:0]  e;
      logic [9:0]  m;
      logic [10:0] mm;
      int          ee;
      s = h[15];
      e = h[14:10];
      m = h[9:0];
      if (e == 5'h1F) return {s, 8'hFF, m, 13'b0};
      if (e == 5'h00) begin
         if (m == 10'h000 || f) return {s, 31'b0};
         mm = {1'b0, m};
         ee = 113;
         while (!mm[10]) begin
            mm = mm << 1;
            ee = ee - 1;
         end
         return {s, 8'(ee), mm[9:0], 13'b0};
      end
      return {s, 8'({3'b000, e} + 8'd112), m, 13'b0};
   endfunction

   function automatic string req_tag(input logic [15:0] h, input logic f);
      if (h[14:10] == 5'h1F)
         return (!h[9] && h[9:0] != 0) ? "R3" : "R2";
      if (h[14:10] == 5'h00)
         return (h[9:0] == 0) ? "R4" : (f ? "R6" : "R5");
      return "R1";
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] got, input logic [31:0] exp_v);
      checks++;
      if (got !== exp_v) begin
         fails++;
         $display("FAIL %s %s in=%h flush=%b got=%h expected=%h",
                  tag, what, in_half, flush_sub, got, exp_v);
      end
   endtask

   // Drive at negedge; combinational copy checked at once, registered copy
   // checked after the next rising edge (R7 latency).
   task automatic apply(input logic [15:0] h, input logic f,
                        input logic [31:0] exp_v, input string tag);
      @(negedge clk);
      in_half   = h;
      flush_sub = f;
      #1;
      check(tag, "comb", out_comb, exp_v);
      @(posedge clk);
      #1;
      check(tag, "reg", out_reg_q, exp_v);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      in_half = 16'h3C00;
      repeat (3) @(posedge clk);
      #1;
      check("R7", "reset value", out_reg_q, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R7", "comb during reset release", out_comb, 32'h3F800000);
   endtask

   task automatic t_latency;
      @(negedge clk);
      in_half = 16'h4000;
      flush_sub = 1'b0;
      #1;
      check("R7", "comb same cycle", out_comb, 32'h40000000);
      check("R7", "reg holds previous", out_reg_q, 32'h3F800000);
      @(posedge clk);
      #1;
      check("R7", "reg one cycle later", out_reg_q, 32'h40000000);
   endtask

   task automatic t_directed;
      apply(16'h0000, 1'b0, 32'h00000000, "R4");
      apply(16'h8000, 1'b0, 32'h80000000, "R4");
      apply(16'h8000, 1'b1, 32'h80000000, "R6");
      apply(16'h7C00, 1'b0, 32'h7F800000, "R2");
      apply(16'hFC00, 1'b0, 32'hFF800000, "R2");
      apply(16'h7E00, 1'b0, 32'h7FC00000, "R2");
      apply(16'h7C01, 1'b0, 32'h7F802000, "R3");
      apply(16'hFD55, 1'b1, 32'hFFAAA000, "R3");
      apply(16'h03FF, 1'b0, 32'h387FC000, "R5");
      apply(16'h0001, 1'b0, 32'h33800000, "R5");
      apply(16'h8001, 1'b0, 32'hB3800000, "R5");
      apply(16'h0200, 1'b0, 32'h38000000, "R5");
      apply(16'h83FF, 1'b1, 32'h80000000, "R6");
      apply(16'h0001, 1'b1, 32'h00000000, "R6");
      apply(16'h0400, 1'b0, 32'h38800000, "R1");
      apply(16'h0400, 1'b1, 32'h38800000, "R6");
      apply(16'h7BFF, 1'b0, 32'h477FE000, "R1");
      apply(16'hBC00, 1'b1, 32'hBF800000, "R6");
   endtask

   task automatic t_sweep(input logic f);
      for (int i = 0; i < 65536; i++) begin
         logic [15:0] h;
         h = 16'(i);
         apply(h, f, ref_conv(h, f), req_tag(h, f));
      end
   endtask

   initial begin
      t_reset();
      t_latency();
      t_directed();
      t_sweep(1'b0);
      t_sweep(1'b1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired after 190000 cycles");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule